// File: doc/BRIEF.md
# Oscillator Control and Stop-Flag Register

This block holds the one-byte control and status register for a timekeeping oscillator. Software writes a byte to stop or run the oscillator, to switch off stop sensing, and to switch on a glitch filter on the oscillator's running indicator. The block also keeps a sticky stop flag. The flag marks that the time base was interrupted at some point, so the stored time may not be trusted.

The oscillator itself is outside the block. It arrives as a running indicator that is already synchronous to the system clock. The block gates that indicator with the stop request. It then passes the result either straight through a register or through a debounce counter. The filter window is a whole number of ticks of a time-base strobe and is set by parameters: clock rate in MHz times window in microseconds. The filtered result drives the clock-valid output, and a falling edge on that output is the stop event that sets the flag.

Top module: `osc_ctl_top`

## Requirements
- R1: After power-on reset, the readback byte is 0x04 (only the stop flag at bit 2 is set), the oscillator enable is 1 and clock-valid is 0.
- R2: Bit 7 of a written byte is the stop request. A 1 drives the oscillator enable to 0 and a 0 drives it to 1, starting on the cycle after the write.
- R3: While the stop request is 1, the running indicator is treated as stopped. Clock-valid falls, and with stop sensing on, the stop flag sets.
- R4: With sense-disable clear, the stop flag (bit 2) sets one cycle after clock-valid goes from 1 to 0. A 0-to-1 change on clock-valid never sets it.
- R5: A write with bit 2 equal to 0 clears the stop flag. A write with bit 2 equal to 1 leaves it unchanged and cannot set it.
- R6: While the sense-disable bit (bit 6) is 1, the stop flag reads 0 and stop events are ignored.
- R7: A write that clears the flag in the same cycle as a stop event leaves the flag set.
- R8: Bits 4, 3, 1 and 0 of the readback are always 0, whatever was written.
- R9: With the filter-enable bit (bit 5) at 0, clock-valid equals the gated running indicator delayed by one clock.
- R10: With the filter-enable bit at 1, clock-valid changes only after the gated indicator has differed from it for FILT_TICKS consecutive ticks. A shorter pulse is suppressed.
- R11: Bits 7, 6 and 5 read back the last written values, from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write byte |
| osc_run_i | input | 1 | Synchronized oscillator-running indicator |
| tick_i | input | 1 | Time-base strobe for the glitch window |
| rd_data | output | 8 | Register readback |
| osc_en_o | output | 1 | Oscillator enable (inverse of stop request) |
| clk_valid_o | output | 1 | Filtered oscillator-valid indication |

## Verification
Most internal faults show up at the ports within one or two cycles. A wrong control bit changes both the readback and the oscillator enable on the cycle after the write. A wrong stop-event path shows up in bit 2 of the readback on the cycle after clock-valid falls. A miscounting filter shifts the edge of clock-valid by one tick or more relative to a window counted from the stimulus, and a glitch of one tick less than the window leaking through changes clock-valid at once. The bench keeps a cycle model written from the requirements and compares every output field on every cycle, so a divergence is reported on the first cycle it appears.

// File: rtl/osc_ctl_pkg.sv
package osc_ctl_pkg;
   localparam int unsigned BIT_STOP   = 7;
   localparam int unsigned BIT_NOSENSE = 6;
   localparam int unsigned BIT_FILT   = 5;
   localparam int unsigned BIT_FLAG   = 2;
   localparam int unsigned REG_W      = 8;

   typedef struct packed {
      logic stop_req;
      logic sense_off;
      logic filt_on;
   } osc_ctl_t;
endpackage

// File: rtl/osc_ctl_reg.sv
module osc_ctl_reg
   import osc_ctl_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output osc_ctl_t         ctl_o
);
   osc_ctl_t ctl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else if (wr_en) begin
         ctl_q.stop_req  <= wr_data[BIT_STOP];
         ctl_q.sense_off <= wr_data[BIT_NOSENSE];
         ctl_q.filt_on   <= wr_data[BIT_FILT];
      end
   end

   assign ctl_o = ctl_q;

   AST_WR_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (ctl_o.stop_req == $past(wr_data[BIT_STOP])) &&
                (ctl_o.filt_on == $past(wr_data[BIT_FILT]))); // R11
endmodule

// File: rtl/osc_valid_filter.sv
module osc_valid_filter #(
   parameter int unsigned FILT_TICKS = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic tick_i,
   input  logic filt_on_i,
   output logic valid_o,
   output logic fall_o
);
   localparam int unsigned CW = (FILT_TICKS > 1) ? $clog2(FILT_TICKS) : 1;

   logic valid_q, valid_d, fall_q;
   logic mismatch;

   assign mismatch = (run_i != valid_q);

   generate
      if (FILT_TICKS < 1) begin : g_bad_cfg
         $error("osc_valid_filter: FILT_TICKS must be at least 1");
      end

      if (FILT_TICKS == 1) begin : g_single
         always_comb begin
            if (!filt_on_i)
               valid_d = run_i;
            else if (mismatch && tick_i)
               valid_d = run_i;
            else
               valid_d = valid_q;
         end
      end else begin : g_count
         logic [CW-1:0] cnt_q;
         logic          win_done;

         assign win_done = (cnt_q == CW'(FILT_TICKS - 1));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (!filt_on_i || !mismatch)
               cnt_q <= '0;
            else if (tick_i)
               cnt_q <= win_done ? '0 : cnt_q + 1'b1;
         end

         always_comb begin
            if (!filt_on_i)
               valid_d = run_i;
            else if (mismatch && tick_i && win_done)
               valid_d = run_i;
            else
               valid_d = valid_q;
         end

         AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            int'(cnt_q) < FILT_TICKS); // R10
         AST_GLITCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (filt_on_i && cnt_q == '0 && mismatch) |=> $stable(valid_o)); // R10
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         fall_q  <= 1'b0;
      end else begin
         valid_q <= valid_d;
         fall_q  <= valid_q & ~valid_d;
      end
   end

   assign valid_o = valid_q;
   assign fall_o  = fall_q;

   AST_BYPASS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      !filt_on_i |=> (valid_o == $past(run_i))); // R9
endmodule

// File: rtl/osc_stop_flag.sv
module osc_stop_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic fall_i,
   input  logic sense_off_i,
   input  logic wr_en,
   input  logic wr_flag_bit,
   output logic flag_o
);
   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag_q <= 1'b1;
      else if (sense_off_i)
         flag_q <= 1'b0;
      else if (fall_i)
         flag_q <= 1'b1;
      else if (wr_en && !wr_flag_bit)
         flag_q <= 1'b0;
   end

   assign flag_o = flag_q;

   AST_SENSE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      sense_off_i |=> !flag_o); // R6
   AST_FALL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (fall_i && !sense_off_i) |=> flag_o); // R7
   AST_NO_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (!fall_i && !flag_o) |=> !flag_o); // R5
endmodule

// File: rtl/osc_ctl_top.sv
module osc_ctl_top
   import osc_ctl_pkg::*;
#(
   parameter int unsigned SYS_CLK_MHZ = 200,
   parameter int unsigned FILT_US     = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] wr_data,
   input  logic       osc_run_i,
   input  logic       tick_i,
   output logic [7:0] rd_data,
   output logic       osc_en_o,
   output logic       clk_valid_o
);
   localparam int unsigned FILT_TICKS = SYS_CLK_MHZ * FILT_US;

   generate
      if (FILT_TICKS == 0) begin : g_bad_window
         $error("osc_ctl_top: glitch window evaluates to zero ticks");
      end
   endgenerate

   osc_ctl_t ctl;
   logic     run_eff;
   logic     fall;
   logic     flag;

   osc_ctl_reg u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .ctl_o   (ctl)
   );

   assign run_eff = osc_run_i & ~ctl.stop_req;

   osc_valid_filter #(.FILT_TICKS(FILT_TICKS)) u_filt (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (run_eff),
      .tick_i    (tick_i),
      .filt_on_i (ctl.filt_on),
      .valid_o   (clk_valid_o),
      .fall_o    (fall)
   );

   osc_stop_flag u_flag (
      .clk         (clk),
      .rst_n       (rst_n),
      .fall_i      (fall),
      .sense_off_i (ctl.sense_off),
      .wr_en       (wr_en),
      .wr_flag_bit (wr_data[BIT_FLAG]),
      .flag_o      (flag)
   );

   always_comb begin
      rd_data              = '0;
      rd_data[BIT_STOP]    = ctl.stop_req;
      rd_data[BIT_NOSENSE] = ctl.sense_off;
      rd_data[BIT_FILT]    = ctl.filt_on;
      rd_data[BIT_FLAG]    = flag;
   end

   assign osc_en_o = ~ctl.stop_req;

   AST_STOP_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.stop_req && !ctl.filt_on) |=> !clk_valid_o); // R3
   AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (osc_en_o == !$past(wr_data[7]))); // R2
   AST_FALL_TO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(clk_valid_o) && !ctl.sense_off) |=> rd_data[2]); // R4
endmodule

// File: tb/sim_osc_ctl_top.sv
module sim_osc_ctl_top;
   localparam int unsigned MHZ = 4;
   localparam int unsigned US  = 2;
   localparam int unsigned F   = MHZ * US;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       osc_run_i = 1'b0;
   logic       tick_i = 1'b1;
   logic [7:0] rd_data;
   logic       osc_en_o;
   logic       clk_valid_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   osc_ctl_top #(.SYS_CLK_MHZ(MHZ), .FILT_US(US)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .osc_run_i(osc_run_i), .tick_i(tick_i), .rd_data(rd_data),
      .osc_en_o(osc_en_o), .clk_valid_o(clk_valid_o)
   );

   // cycle model built from the requirements
   logic m_stop, m_nosense, m_filt, m_flag, m_valid, m_fall;
   int   m_cnt;

   function automatic logic next_valid(input logic run, input logic cur,
                                       input logic filt, input logic tk,
                                       input int cnt);
      if (!filt) return run;
      if (run != cur && tk && cnt == F - 1) return run;
      return cur;
   endfunction

   function automatic logic [7:0] exp_rd();
      return {m_stop, m_nosense, m_filt, 2'b00, m_flag, 2'b00};
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_stop <= 0; m_nosense <= 0; m_filt <= 0;
         m_flag <= 1; m_valid <= 0; m_fall <= 0; m_cnt <= 0;
      end else begin : mdl
         logic re, nv;
         re = osc_run_i & ~m_stop;
         nv = next_valid(re, m_valid, m_filt, tick_i, m_cnt);
         m_valid <= nv;
         m_fall  <= m_valid & ~nv;
         if (!m_filt || re == m_valid) m_cnt <= 0;
         else if (tick_i) m_cnt <= (m_cnt == F - 1) ? 0 : m_cnt + 1;
         if (m_nosense) m_flag <= 0;
         else if (m_fall) m_flag <= 1;
         else if (wr_en && !wr_data[2]) m_flag <= 0;
         if (wr_en) begin
            m_stop <= wr_data[7]; m_nosense <= wr_data[6]; m_filt <= wr_data[5];
         end
      end
   end

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R11 ctl bits", {5'b0, rd_data[7:5]}, {5'b0, exp_rd() >> 5});
         chk("R8 reserved bits", {4'b0, rd_data[4:3], rd_data[1:0]}, 8'h00);
         chk("R4 flag bit", {7'b0, rd_data[2]}, {7'b0, m_flag});
         chk("R2 osc enable", {7'b0, osc_en_o}, {7'b0, ~m_stop});
         chk("R10 clk valid", {7'b0, clk_valid_o}, {7'b0, m_valid});
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] d);
      @(negedge clk); wr_en = 1'b1; wr_data = d;
      @(negedge clk); wr_en = 1'b0; wr_data = $urandom;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #1000000;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      void'($urandom(32'h5eed1234));
      idle(2);
      chk("R1 reset readback", rd_data, 8'h04);
      chk("R1 reset enable", {7'b0, osc_en_o}, 8'h01);
      chk("R1 reset valid", {7'b0, clk_valid_o}, 8'h00);
      @(negedge clk); rst_n = 1'b1;

      osc_run_i = 1'b1; idle(2);
      chk("R9 bypass follows run", {7'b0, clk_valid_o}, 8'h01);
      chk("R4 rising edge keeps power-up flag", {7'b0, rd_data[2]}, 8'h01);
      wr(8'h00);
      chk("R5 clear flag", rd_data, 8'h00);
      wr(8'h04);
      chk("R5 write one does not set", rd_data, 8'h00);

      wr(8'hDB); idle(1);
      chk("R8 R11 readback after 0xDB", rd_data, 8'hC0);
      chk("R2 enable low on stop", {7'b0, osc_en_o}, 8'h00);
      wr(8'h00); idle(2);
      chk("R2 enable back high", {7'b0, osc_en_o}, 8'h01);

      // R7: clear in same cycle as stop event
      osc_run_i = 1'b0;
      wr(8'h00);
      chk("R7 clear collides with stop", {7'b0, rd_data[2]}, 8'h01);
      osc_run_i = 1'b1; idle(2);
      wr(8'h00);

      // R3: stop request
      wr(8'h80); idle(2);
      chk("R3 valid drops on stop request", {7'b0, clk_valid_o}, 8'h00);
      chk("R3 flag set by stop request", {7'b0, rd_data[2]}, 8'h01);
      wr(8'h00); idle(2); wr(8'h00);

      // R6: sensing disabled
      wr(8'h40);
      osc_run_i = 1'b0; idle(3);
      chk("R6 flag held low", {7'b0, rd_data[2]}, 8'h00);
      osc_run_i = 1'b1; idle(2);
      wr(8'h00);

      // R10: filter on, short glitch suppressed
      wr(8'h20); idle(1);
      osc_run_i = 1'b0;
      for (int i = 0; i < F - 1; i++) begin
         @(negedge clk);
         chk("R10 glitch held", {7'b0, clk_valid_o}, 8'h01);
      end
      osc_run_i = 1'b1; idle(2);
      chk("R10 no flag after glitch", {7'b0, rd_data[2]}, 8'h00);
      osc_run_i = 1'b0; idle(F + 2);
      chk("R10 long stop passes filter", {7'b0, clk_valid_o}, 8'h00);
      chk("R4 flag after filtered stop", {7'b0, rd_data[2]}, 8'h01);
      osc_run_i = 1'b1; idle(F + 2);

      // constrained random phase
      for (int c = 0; c < 4000; c++) begin
         @(negedge clk);
         tick_i = ($urandom % 4) != 0;
         if (($urandom % 5) == 0) osc_run_i = ~osc_run_i;
         if (($urandom % 16) == 0) begin
            wr_en = 1'b1;
            wr_data = $urandom & 8'hBF;
            if (($urandom % 8) == 0) wr_data[6] = 1'b1;
         end else begin
            wr_en = 1'b0;
         end
      end
      wr_en = 1'b0;
      idle(2);
      finish_run();
   end
endmodule